// File: doc/BRIEF.md
# Serial Port Interrupt Identification Logic

This block merges the interrupt sources of a classic asynchronous serial port into a single interrupt line and a read-only identification byte. The receiver, transmitter and modem-status logic stay outside. They deliver their status flags as plain inputs: data ready, four receive error flags, the transmitter-holding-empty flag and four modem-status change flags. Software writes a 4-bit enable field over a small register bus. Each enable bit gates one source group. A fixed priority encoder then picks the most urgent enabled group and reports it in the identification byte.

The holding-empty condition is an event, not a level. A small two-state machine (`HE_IDLE`, `HE_ARMED`) catches each rising edge of the empty flag. The transition `ARM` moves `HE_IDLE` to `HE_ARMED` on a rising edge of the flag when no clear is requested. The transition `ACK` returns `HE_ARMED` to `HE_IDLE` when the identification byte is read while it reports holding-empty. The transition `LOAD` does the same when the holding register is written. The transition `DRAIN` does the same when the empty flag falls. When a clear and a rising edge fall in one cycle, the clear wins and the machine stays in `HE_IDLE`.

The identification byte and the interrupt output are both registered. They reflect the source flags, the enable field and the machine state of the cycle before.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the identification byte reads 0x01, `irq` is low and the enable field reads 0x00.
- R2: A write to address 1 stores `reg_wdata[3:0]` as the enable field. Reading address 1 returns the field in bits 3:0, with bits 7:4 reading 0. Bit 0 enables received data, bit 1 enables holding-empty, bit 2 enables line status and bit 3 enables modem status.
- R3: If any of overrun, parity, framing or break (`line_err`) is set while enable bit 2 is set, the identification byte reads 0x06 (ID 11, bit 0 low). This beats every other source.
- R4: If `data_ready` is set while enable bit 0 is set and no enabled line status is present, the identification byte reads 0x04 (ID 10). This beats holding-empty and modem status.
- R5: A rising edge of `hold_empty` arms the holding-empty condition. While it stays armed, the flag is high and enable bit 1 is set, the byte reads 0x02 (ID 01) unless a higher source is present. A later rising edge re-arms it.
- R6: Any modem change flag (`modem_delta`) with enable bit 3 set and no higher source gives 0x00 (ID 00).
- R7: When no enabled source is active, the byte reads 0x01 and `irq` is low. A source whose enable bit is clear has no effect.
- R8: A read strobe at address 2 while the byte reports 0x02 clears the holding-empty condition. It stays clear while `hold_empty` remains high.
- R9: A write strobe at address 0 (the holding register) clears the holding-empty condition.
- R10: A read of address 2 while it reports any value other than 0x02 leaves an armed holding-empty condition in place.
- R11: A falling `hold_empty` drops the armed condition.
- R12: The byte and `irq` change on the clock edge after the input or enable change, and `irq` is high exactly when byte bit 0 is 0.
- R13: A clear (R8 or R9) in the same cycle as a rising edge of `hold_empty` wins, and the condition is not armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only) |
| reg_addr | input | 2 | 0 holding register, 1 enable field, 2 identification byte |
| reg_wdata | input | 4 | Enable field write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| data_ready | input | 1 | Received byte available |
| line_err | input | 4 | {break, framing, parity, overrun} |
| hold_empty | input | 1 | Transmit holding register empty |
| modem_delta | input | 4 | {carrier change, ring trailing edge, set-ready change, clear-to-send change} |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two events can land on the holding-empty machine in the same cycle, and the bench aims at both.

The first case is a rising edge of `hold_empty` driven together with a holding-register write. It is judged by checking that the byte stays 0x01 on the following cycles while the flag holds high.

The second case is an acknowledging read of 0x02 in the cycle a line error arrives. It is judged by checking that the line status shows first (0x06). When the error drops, the byte should return to 0x01 rather than 0x02, which proves the read was taken.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [1:0] {
        ID_MODEM  = 2'b00,
        ID_THRE   = 2'b01,
        ID_RXDATA = 2'b10,
        ID_LINE   = 2'b11
    } irq_id_e;

    typedef enum logic {
        HE_IDLE  = 1'b0,
        HE_ARMED = 1'b1
    } he_state_e;

    localparam logic [1:0] ADDR_HOLD   = 2'd0;
    localparam logic [1:0] ADDR_ENABLE = 2'd1;
    localparam logic [1:0] ADDR_IDENT  = 2'd2;

    localparam int EN_RX    = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

endpackage

// File: rtl/uart_irq_enable_reg.sv
module uart_irq_enable_reg #(
    parameter int EN_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [EN_W-1:0] wdata,
    output logic [EN_W-1:0] en_q,
    output logic [EN_W-1:0] en_nxt
);

    always_comb begin
        en_nxt = wr_en ? wdata : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_nxt;
    end

    // R2
    en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wdata)));

endmodule

// File: rtl/uart_irq_hold_fsm.sv
module uart_irq_hold_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_empty,
    input  logic clear_req,
    output logic armed_q,
    output logic armed_nxt
);

    he_state_e state_q, state_d;
    logic      flag_prev_q;
    logic      rise;

    assign rise = hold_empty & ~flag_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= HE_IDLE;
            flag_prev_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            flag_prev_q <= hold_empty;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HE_IDLE: begin
                if (rise && !clear_req)             state_d = HE_ARMED;   // ARM
            end
            HE_ARMED: begin
                if (clear_req || !hold_empty)       state_d = HE_IDLE;    // ACK / LOAD / DRAIN
            end
            default:                                state_d = HE_IDLE;
        endcase
    end

    always_comb begin
        armed_q   = (state_q == HE_ARMED);
        armed_nxt = (state_d == HE_ARMED);
    end

    // R8 R9 R13
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (state_q == HE_IDLE));

    // R5
    arm_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HE_IDLE && hold_empty && !flag_prev_q && !clear_req) |=> (state_q == HE_ARMED));

    // R11
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_empty |=> (state_q == HE_IDLE));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic    line_src,
    input  logic    rx_src,
    input  logic    thre_src,
    input  logic    modem_src,
    output logic    pend,
    output irq_id_e id
);

    always_comb begin
        pend = 1'b1;
        if (line_src)       id = ID_LINE;
        else if (rx_src)    id = ID_RXDATA;
        else if (thre_src)  id = ID_THRE;
        else if (modem_src) id = ID_MODEM;
        else begin
            id   = ID_MODEM;
            pend = 1'b0;
        end
    end

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int EN_W    = 4,
    parameter int LINE_N  = 4,
    parameter int MODEM_N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [1:0]         reg_addr,
    input  logic [EN_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               data_ready,
    input  logic [LINE_N-1:0]  line_err,
    input  logic               hold_empty,
    input  logic [MODEM_N-1:0] modem_delta,
    output logic               irq
);

    localparam int ID_PAD = DATA_W - 3;
    localparam int EN_PAD = DATA_W - EN_W;

    logic [EN_W-1:0] en_q, en_nxt;
    logic            armed_q, armed_nxt;
    logic            clear_req;
    logic            line_src, rx_src, thre_src, modem_src;
    logic            pend_d;
    irq_id_e         id_d, id_q;
    logic            pend_q;
    logic [DATA_W-1:0] id_byte;

    uart_irq_enable_reg #(.EN_W(EN_W)) u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr && reg_addr == ADDR_ENABLE),
        .wdata  (reg_wdata),
        .en_q   (en_q),
        .en_nxt (en_nxt)
    );

    assign id_byte   = {{ID_PAD{1'b0}}, id_q, ~pend_q};
    assign clear_req = (reg_wr && reg_addr == ADDR_HOLD) ||
                       (reg_rd && reg_addr == ADDR_IDENT && pend_q && id_q == ID_THRE);

    uart_irq_hold_fsm u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_empty (hold_empty),
        .clear_req  (clear_req),
        .armed_q    (armed_q),
        .armed_nxt  (armed_nxt)
    );

    always_comb begin
        line_src  = en_nxt[EN_LINE]  & (|line_err);
        rx_src    = en_nxt[EN_RX]    & data_ready;
        thre_src  = en_nxt[EN_THRE]  & armed_nxt & hold_empty;
        modem_src = en_nxt[EN_MODEM] & (|modem_delta);
    end

    uart_irq_prio u_prio (
        .line_src  (line_src),
        .rx_src    (rx_src),
        .thre_src  (thre_src),
        .modem_src (modem_src),
        .pend      (pend_d),
        .id        (id_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= ID_MODEM;
            pend_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            id_q   <= id_d;
            pend_q <= pend_d;
            irq    <= pend_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_ENABLE: reg_rdata = {{EN_PAD{1'b0}}, en_q};
            ADDR_IDENT:  reg_rdata = id_byte;
            default:     reg_rdata = '0;
        endcase
    end

    // R3
    line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_nxt[EN_LINE] && (|line_err)) |=> (id_byte[2:0] == 3'b110 && irq));

    // R4
    rx_over_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_nxt[EN_RX] && data_ready && !(en_nxt[EN_LINE] && (|line_err))) |=> (id_byte[2:0] == 3'b100));

    // R7
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((en_nxt[EN_LINE] && (|line_err)) || (en_nxt[EN_RX] && data_ready) ||
          (en_nxt[EN_MODEM] && (|modem_delta)) || (en_nxt[EN_THRE] && hold_empty))
        |=> (id_byte == 8'h01 && !irq));

    // R12
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !id_byte[0]);

endmodule

// File: tb/uart_irq_id_bench.sv
module uart_irq_id_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [3:0] reg_wdata = 4'd0;
    logic [7:0] reg_rdata;
    logic       data_ready = 1'b0;
    logic [3:0] line_err = 4'd0;
    logic       hold_empty = 1'b0;
    logic [3:0] modem_delta = 4'd0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    uart_irq_id u_uart_irq_id (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .data_ready(data_ready), .line_err(line_err), .hold_empty(hold_empty),
        .modem_delta(modem_delta), .irq(irq)
    );

    // {en[3:0], line[3:0], dr, modem[3:0], expected id[7:0]}
    localparam logic [20:0] VEC [12] = '{
        {4'hf, 4'h0, 1'b0, 4'h0, 8'h01},
        {4'hf, 4'h1, 1'b1, 4'hf, 8'h06},
        {4'hf, 4'h0, 1'b1, 4'hf, 8'h04},
        {4'hf, 4'h0, 1'b0, 4'h1, 8'h00},
        {4'h7, 4'h0, 1'b0, 4'hf, 8'h01},
        {4'hb, 4'h8, 1'b0, 4'h0, 8'h01},
        {4'he, 4'h0, 1'b1, 4'h0, 8'h01},
        {4'h4, 4'h2, 1'b1, 4'h0, 8'h06},
        {4'h1, 4'h0, 1'b1, 4'h2, 8'h04},
        {4'h8, 4'h0, 1'b0, 4'h4, 8'h00},
        {4'hf, 4'h4, 1'b0, 4'h8, 8'h06},
        {4'h9, 4'h0, 1'b1, 4'h1, 8'h04}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic read_id(output logic [7:0] v);
        reg_addr = 2'd2;
        #1 v = reg_rdata;
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic set_en(input logic [3:0] e);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = e;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        read_id(v); chk("R1 id", v, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        reg_addr = 2'd1; #1 chk("R1 enable", reg_rdata, 8'h00);

        // table walk: R2 R3 R4 R6 R7 R12
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = VEC[i][20:17];
            line_err = VEC[i][16:13]; data_ready = VEC[i][12]; modem_delta = VEC[i][11:8];
            @(negedge clk);
            reg_wr = 1'b0;
            #1 chk("R2 enable readback", reg_rdata, {4'h0, VEC[i][20:17]});
            read_id(v); chk("R3/R4/R6/R7 id", v, VEC[i][7:0]);
            chk("R12 irq", {7'd0, irq}, {7'd0, VEC[i][7:0] != 8'h01});
        end
        line_err = 0; data_ready = 0; modem_delta = 0;
        set_en(4'h1);
        @(negedge clk);

        // R12 latency: output unchanged before the edge
        data_ready = 1'b1;
        read_id(v); chk("R12 before edge", v, 8'h01);
        step(); read_id(v); chk("R12 after edge", v, 8'h04);
        data_ready = 1'b0; step();

        // R5 arm, R8 clear by read
        set_en(4'h2);
        hold_empty = 1'b1;
        step(); read_id(v); chk("R5 armed", v, 8'h02);
        chk("R5 irq", {7'd0, irq}, 8'h01);
        reg_rd = 1'b1; step(); reg_rd = 1'b0;
        read_id(v); chk("R8 cleared", v, 8'h01);
        step(); step(); read_id(v); chk("R8 stays clear", v, 8'h01);
        hold_empty = 1'b0; step(); hold_empty = 1'b1;
        step(); read_id(v); chk("R5 re-arm", v, 8'h02);

        // R9 holding write
        reg_wr = 1'b1; reg_addr = 2'd0; step(); reg_wr = 1'b0;
        read_id(v); chk("R9 write clears", v, 8'h01);

        // R11 drain
        hold_empty = 1'b0; step(); hold_empty = 1'b1;
        step(); read_id(v); chk("R11 armed", v, 8'h02);
        hold_empty = 1'b0; step(); read_id(v); chk("R11 drained", v, 8'h01);
        hold_empty = 1'b1; step(); read_id(v); chk("R11 re-armed", v, 8'h02);
        hold_empty = 1'b0; step();

        // R10 read of another ID keeps the condition
        set_en(4'h6);
        hold_empty = 1'b1; line_err = 4'h1;
        step(); read_id(v); chk("R10 line first", v, 8'h06);
        reg_rd = 1'b1; step(); reg_rd = 1'b0;
        line_err = 4'h0;
        step(); read_id(v); chk("R10 hold survives", v, 8'h02);

        // acknowledge read coinciding with a new line error (R8)
        reg_rd = 1'b1; line_err = 4'h8; step(); reg_rd = 1'b0;
        read_id(v); chk("R8 line shows", v, 8'h06);
        line_err = 4'h0; step(); read_id(v); chk("R8 ack taken", v, 8'h01);
        hold_empty = 1'b0; step();

        // R13 rise with holding write in one cycle
        hold_empty = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0;
        step(); reg_wr = 1'b0;
        read_id(v); chk("R13 clear wins", v, 8'h01);
        step(); step(); read_id(v); chk("R13 stays idle", v, 8'h01);
        chk("R13 irq", {7'd0, irq}, 8'h00);

        finish_run();
    end

endmodule